// File: doc/BRIEF.md
# Priority Interrupt Controller with Masking

This block sits between a set of interrupt request lines and a CPU. Every source owns a 4-bit priority level. The levels are packed four to a register in eight priority registers. Level 0 switches a source off. Each source is set to follow its input as a level, or to latch a rising edge as a pending event. The block scans the pending sources, picks the highest level, and compares that level with the mask level supplied by the CPU. It then offers the winner to the CPU with its level and a fixed vector number.

The request to the CPU is a valid/ready pair. `irq_valid`, `irq_level` and `irq_vector` are registered and are rebuilt every cycle from the arbitration result. While `irq_ready` is low, the offer may be replaced by a higher request or withdrawn; it is not frozen. A handshake happens only on a cycle where `irq_valid` and `irq_ready` are both high. On that cycle:
- the accepted level becomes `mask_out` on the next cycle;
- the latch of an edge-mode source is cleared;
- the accepted source is left out of the next arbitration.

Software reaches the priority, mode and pending-status registers through a simple write strobe and a combinational read port. Writing ones to the status register clears latched edges.

Register map (word addresses):
- 0 to 7: priority registers. Source `s` is held in register `s/4`, in bits `[4*(s%4)+3 : 4*(s%4)]`. Bits 31:16 are ignored on write and read as 0.
- 8: mode register. Bit `s` set to 1 selects edge detection for source `s`; 0 selects level.
- 9: pending status. Bit `s` reads the edge latch of source `s`; writing 1 clears it.
- Any other address reads 0.

The vector number of source `s` is `VEC_BASE + s`, with `VEC_BASE` = 64 by default. `NUM_SRC` must be a multiple of 4 and no more than 32.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset, `irq_valid` and `mask_out` are 0, every priority field is 0, all sources are in level mode, and the status register reads 0.
- R2: Register reads return the register map above: priority fields in their stated bit positions with bits 31:16 reading 0, the mode register at address 8, the edge latches at address 9, and 0 elsewhere.
- R3: A source whose priority field is 0 is never offered, whatever its input.
- R4: Among pending sources, the one with the highest level is offered, with `irq_level` equal to that level and `irq_vector` equal to `VEC_BASE` + source index.
- R5: When several pending sources share the highest level, the lowest source index wins.
- R6: A request is offered only if its level is strictly greater than `cpu_mask`; an equal or lower level leaves `irq_valid` at 0.
- R7: `irq_valid`, `irq_level` and `irq_vector` change one cycle after the inputs, register contents or latches they are computed from.
- R8: On a cycle where `irq_valid` and `irq_ready` are both 1, `mask_out` takes the offered `irq_level` on the next cycle; otherwise `mask_out` holds.
- R9: In edge mode (mode bit 1), a rising input sets the pending latch on that clock edge. The latch stays set after the input falls, until it is accepted or cleared; status bit `s` reads 1 while it is set.
- R10: Acceptance clears the accepted source's edge latch, and the accepted source is not offered in the cycle right after acceptance.
- R11: Writing 1 to status bit `s` clears that latch and writing 0 leaves it. A rising edge in the same cycle as the clear wins, and the latch stays set.
- R12: In level mode, a source is pending exactly while its input is 1; nothing is latched.
- R13: While `irq_ready` is 0, a newly pending higher request replaces the offered one with no handshake, and `mask_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears all latches and registers |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_in | input | NUM_SRC | Interrupt request inputs, one per source |
| cpu_mask | input | 4 | Current CPU mask level |
| irq_valid | output | 1 | Request offered to the CPU |
| irq_ready | input | 1 | CPU accepts the offered request |
| irq_level | output | 4 | Level of the offered request |
| irq_vector | output | VEC_W | Vector number of the offered request |
| mask_out | output | 4 | Mask level to adopt, set to the last accepted level |

## Verification
Directed patterns try the main function in several settings:
- two sources at different levels, to tell priority from index order;
- two sources at the same level, so that only the tie rule can decide;
- the mask set equal to the winning level and then one below it, to separate a strict comparison from a non-strict one;
- a high source raised while the CPU holds back, to show the offer changes without a handshake.

Edge sources are pulsed once and then checked against acceptance, a status write of 0, a status write of 1, and a clear that collides with a new edge. These tell latched pending from input-following pending, and show which side wins the collision. A long constrained-random run then mixes sparse request patterns, random priority and mode writes, random masks and random ready. It compares every cycle with a bench model, which exposes tie-order, exclusion and timing errors that the directed cases miss.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int LVL_W          = 4;
  localparam int FIELDS_PER_REG = 4;
  localparam int DATA_W         = 32;
  localparam int ADDR_W         = 4;
  typedef logic [LVL_W-1:0] level_t;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [DATA_W-1:0]        wdata,
  input  logic [NUM_SRC-1:0]       latch,
  output logic [NUM_SRC*LVL_W-1:0] prio_flat,
  output logic [NUM_SRC-1:0]       edge_mode,
  output logic [NUM_SRC-1:0]       clr_sw,
  output logic [DATA_W-1:0]        rdata
);
  localparam int PRIO_REGS = NUM_SRC / FIELDS_PER_REG;
  localparam int REG_W     = FIELDS_PER_REG * LVL_W;
  localparam int MODE_ADDR = PRIO_REGS;
  localparam int STAT_ADDR = PRIO_REGS + 1;

  logic [PRIO_REGS-1:0][REG_W-1:0] prio_q;
  logic [NUM_SRC-1:0]              mode_q;

  // One storage register per group of four priority fields
  for (genvar r = 0; r < PRIO_REGS; r++) begin : g_prio
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        prio_q[r] <= '0;
      else if (wr_en && addr == ADDR_W'(r))
        prio_q[r] <= wdata[REG_W-1:0];
    end
    assign prio_flat[r*REG_W +: REG_W] = prio_q[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mode_q <= '0;
    else if (wr_en && addr == ADDR_W'(MODE_ADDR))
      mode_q <= wdata[NUM_SRC-1:0];
  end

  assign edge_mode = mode_q;
  assign clr_sw    = (wr_en && addr == ADDR_W'(STAT_ADDR)) ? wdata[NUM_SRC-1:0] : '0;

  always_comb begin
    rdata = '0;
    for (int r = 0; r < PRIO_REGS; r++)
      if (addr == ADDR_W'(r)) rdata[REG_W-1:0] = prio_q[r];
    if (addr == ADDR_W'(MODE_ADDR)) rdata[NUM_SRC-1:0] = mode_q;
    if (addr == ADDR_W'(STAT_ADDR)) rdata[NUM_SRC-1:0] = latch;
  end
endmodule

// File: rtl/irq_prio_detect.sv
module irq_prio_detect #(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [NUM_SRC-1:0] edge_mode,
  input  logic [NUM_SRC-1:0] clr_sw,
  input  logic [NUM_SRC-1:0] clr_ack,
  output logic [NUM_SRC-1:0] latch,
  output logic [NUM_SRC-1:0] pending
);
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    logic prev_r;
    logic lat_r;
    logic rise;
    logic clr;

    assign rise = irq_in[s] & ~prev_r;
    assign clr  = clr_sw[s] | clr_ack[s];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_r <= 1'b0;
        lat_r  <= 1'b0;
      end else begin
        prev_r <= irq_in[s];
        // a new edge outranks any clear arriving in the same cycle
        lat_r  <= edge_mode[s] & (rise | (lat_r & ~clr));
      end
    end

    assign latch[s]   = lat_r;
    assign pending[s] = edge_mode[s] ? lat_r : irq_in[s];
  end
endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC = 32,
  localparam int IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]       pending,
  input  logic [NUM_SRC*LVL_W-1:0] prio_flat,
  output level_t                   best_lvl,
  output logic [IDX_W-1:0]         best_idx
);
  // Ascending scan with a strict compare: the lowest index keeps a tie,
  // and a level of 0 can never beat the initial 0.
  always_comb begin
    best_lvl = '0;
    best_idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && prio_flat[i*LVL_W +: LVL_W] > best_lvl) begin
        best_lvl = prio_flat[i*LVL_W +: LVL_W];
        best_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr_en,
  input  logic [3:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic [3:0]         cpu_mask,
  output logic               irq_valid,
  input  logic               irq_ready,
  output logic [3:0]         irq_level,
  output logic [VEC_W-1:0]   irq_vector,
  output logic [3:0]         mask_out
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC*LVL_W-1:0] prio_flat;
  logic [NUM_SRC-1:0]       edge_mode;
  logic [NUM_SRC-1:0]       clr_sw;
  logic [NUM_SRC-1:0]       clr_ack;
  logic [NUM_SRC-1:0]       latch;
  logic [NUM_SRC-1:0]       pending;
  logic [NUM_SRC-1:0]       pend_eff;
  level_t                   best_lvl;
  logic [IDX_W-1:0]         best_idx;
  logic [IDX_W-1:0]         idx_q;
  logic                     accept;

  irq_prio_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .latch     (latch),
    .prio_flat (prio_flat),
    .edge_mode (edge_mode),
    .clr_sw    (clr_sw),
    .rdata     (reg_rdata)
  );

  assign accept  = irq_valid & irq_ready;
  assign clr_ack = accept ? (NUM_SRC'(1) << idx_q) : '0;

  irq_prio_detect #(.NUM_SRC(NUM_SRC)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_in    (irq_in),
    .edge_mode (edge_mode),
    .clr_sw    (clr_sw),
    .clr_ack   (clr_ack),
    .latch     (latch),
    .pending   (pending)
  );

  // The source being accepted sits out the next arbitration round
  assign pend_eff = pending & ~clr_ack;

  irq_prio_arb #(.NUM_SRC(NUM_SRC)) u_arb (
    .pending   (pend_eff),
    .prio_flat (prio_flat),
    .best_lvl  (best_lvl),
    .best_idx  (best_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_level  <= '0;
      irq_vector <= '0;
      idx_q      <= '0;
      mask_out   <= '0;
    end else begin
      irq_valid  <= best_lvl > cpu_mask;
      irq_level  <= best_lvl;
      irq_vector <= VEC_W'(VEC_BASE) + VEC_W'(best_idx);
      idx_q      <= best_idx;
      if (accept) mask_out <= irq_level;
    end
  end
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       cpu_mask,
  input logic             irq_valid,
  input logic             irq_ready,
  input logic [3:0]       irq_level,
  input logic [VEC_W-1:0] irq_vector,
  input logic [3:0]       mask_out
);
  AST_OFFER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_level != 4'd0); // R3

  AST_ABOVE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_level > $past(cpu_mask)); // R6

  AST_MASK_TAKES_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> mask_out == $past(irq_level)); // R8

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_valid && irq_ready) |=> $stable(mask_out)); // R13

  AST_NO_REOFFER: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && irq_ready) |=> !(irq_valid && irq_vector == $past(irq_vector))); // R10
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cpu_mask   (cpu_mask),
  .irq_valid  (irq_valid),
  .irq_ready  (irq_ready),
  .irq_level  (irq_level),
  .irq_vector (irq_vector),
  .mask_out   (mask_out)
);

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
  localparam int N  = 32;
  localparam int VB = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [N-1:0] irq_in = '0;
  logic [3:0]  cpu_mask = '0;
  logic        irq_valid;
  logic        irq_ready = 1'b0;
  logic [3:0]  irq_level;
  logic [7:0]  irq_vector;
  logic [3:0]  mask_out;

  always #4 clk = ~clk;

  irq_prio_ctrl u_irq_prio_ctrl (
    .clk (clk), .rst_n (rst_n), .reg_wr_en (reg_wr_en), .reg_addr (reg_addr),
    .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .irq_in (irq_in),
    .cpu_mask (cpu_mask), .irq_valid (irq_valid), .irq_ready (irq_ready),
    .irq_level (irq_level), .irq_vector (irq_vector), .mask_out (mask_out)
  );

  int checks = 0;
  int errors = 0;

  // Bench model state
  logic [3:0]  m_prio [N];
  logic [31:0] m_edge, m_latch, m_prev;
  logic        m_valid;
  logic [3:0]  m_level, m_mask;
  int          m_idx;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rdata(input logic [3:0] a);
    logic [31:0] r = '0;
    if (a < 4'd8) begin
      for (int f = 0; f < 4; f++) r[4*f +: 4] = m_prio[4*int'(a) + f];
    end else if (a == 4'd8) r = m_edge;
    else if (a == 4'd9) r = m_latch;
    return r;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) m_prio[i] = '0;
    m_edge = '0; m_latch = '0; m_prev = '0;
    m_valid = 1'b0; m_level = '0; m_mask = '0; m_idx = 0;
  endtask

  task automatic model_edge();
    logic        acc;
    logic [31:0] pend, clr, rise, nlatch;
    logic [3:0]  best;
    int          bidx;
    acc  = m_valid && irq_ready;
    pend = (m_edge & m_latch) | (~m_edge & irq_in);
    if (acc) pend[m_idx] = 1'b0;
    best = '0; bidx = 0;
    for (int i = 0; i < N; i++)
      if (pend[i] && m_prio[i] > best) begin best = m_prio[i]; bidx = i; end
    clr = '0;
    if (acc) clr[m_idx] = 1'b1;
    if (reg_wr_en && reg_addr == 4'd9) clr = clr | reg_wdata;
    rise   = irq_in & ~m_prev;
    nlatch = m_edge & (rise | (m_latch & ~clr));
    if (acc) m_mask = m_level;
    m_valid = best > cpu_mask;
    m_level = best;
    m_idx   = bidx;
    m_latch = nlatch;
    m_prev  = irq_in;
    if (reg_wr_en) begin
      if (reg_addr < 4'd8)
        for (int f = 0; f < 4; f++) m_prio[4*int'(reg_addr) + f] = reg_wdata[4*f +: 4];
      else if (reg_addr == 4'd8) m_edge = reg_wdata;
    end
  endtask

  // One clock: DUT and model advance together, then outputs are compared
  task automatic cycle();
    @(posedge clk);
    model_edge();
    #1;
    chk("R7 irq_valid", irq_valid, m_valid);
    if (m_valid) begin
      chk("R4 irq_level", irq_level, m_level);
      chk("R4 irq_vector", irq_vector, VB + m_idx);
    end
    chk("R8 mask_out", mask_out, m_mask);
    chk("R2 reg_rdata", reg_rdata, exp_rdata(reg_addr));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    cycle();
    reg_wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq_valid", irq_valid, 0);
    chk("R1 mask_out", mask_out, 0);
    rd_chk("R1 status", 4'd9, 0);
    rd_chk("R1 mode", 4'd8, 0);
    rd_chk("R1 prio0", 4'd0, 0);

    // R2 field layout, upper bits ignored
    wr(4'd2, 32'hFFFF_4321);
    rd_chk("R2 prio2 readback", 4'd2, 32'h0000_4321);
    rd_chk("R2 unused addr", 4'd12, 0);

    // R3 level-0 source with active input
    irq_in = 32'h0000_0020;
    cycle();
    chk("R3 disabled source", irq_valid, 0);

    // R4 src3=2, src20=7
    wr(4'd0, 32'h0000_2000);
    wr(4'd5, 32'h0000_0007);
    irq_in = (32'h1 << 3) | (32'h1 << 20) | (32'h1 << 5);
    cycle();
    chk("R4 valid", irq_valid, 1);
    chk("R4 level", irq_level, 7);
    chk("R4 vector", irq_vector, 84);

    // R5 src6 and src12 both level 5
    wr(4'd1, 32'h0000_0500);
    wr(4'd3, 32'h0000_0005);
    irq_in = (32'h1 << 6) | (32'h1 << 12) | (32'h1 << 3);
    cycle();
    chk("R5 tie level", irq_level, 5);
    chk("R5 tie vector", irq_vector, 70);

    // R6 strict mask compare
    cpu_mask = 4'd5;
    cycle();
    chk("R6 equal mask blocks", irq_valid, 0);
    cpu_mask = 4'd4;
    cycle();
    chk("R6 lower mask passes", irq_valid, 1);

    // R13 no handshake: replacement, mask held
    irq_ready = 1'b0;
    cycle();
    chk("R13 mask held", mask_out, 0);
    irq_in = irq_in | (32'h1 << 20);
    cycle();
    chk("R13 replaced vector", irq_vector, 84);
    chk("R13 mask unchanged", mask_out, 0);

    // R8 / R10 handshake
    irq_ready = 1'b1;
    cycle();
    chk("R8 mask takes level", mask_out, 7);
    chk("R10 accepted source skipped", irq_vector, 70);
    irq_ready = 1'b0;
    cpu_mask = 4'd7;
    cycle();
    chk("R6 new mask blocks", irq_valid, 0);

    // R9 edge latch: src1 level 9
    irq_in = '0; cpu_mask = 4'd0;
    wr(4'd0, 32'h0000_0090);
    wr(4'd8, 32'h0000_0002);
    cycle();
    irq_in = 32'h2;
    cycle();
    irq_in = '0;
    cycle();
    chk("R9 latched valid", irq_valid, 1);
    chk("R9 latched vector", irq_vector, 65);
    rd_chk("R9 status bit", 4'd9, 32'h2);
    cycle();
    chk("R9 held after input fell", irq_valid, 1);

    // R10 acceptance clears the latch
    irq_ready = 1'b1;
    cycle();
    irq_ready = 1'b0;
    rd_chk("R10 latch cleared", 4'd9, 0);
    chk("R10 not reoffered", irq_valid, 0);
    chk("R8 mask after edge accept", mask_out, 9);

    // R11 software clear
    irq_in = 32'h2;
    cycle();
    irq_in = '0;
    cycle();
    wr(4'd9, 32'h0);
    rd_chk("R11 write 0 keeps", 4'd9, 32'h2);
    wr(4'd9, 32'h2);
    rd_chk("R11 write 1 clears", 4'd9, 0);
    irq_in = 32'h2;
    wr(4'd9, 32'h2);
    rd_chk("R11 edge wins over clear", 4'd9, 32'h2);
    irq_in = '0;
    wr(4'd9, 32'h2);

    // R12 level mode follows input
    wr(4'd8, 32'h0);
    irq_in = 32'h2;
    cycle();
    chk("R12 level active", irq_valid, 1);
    chk("R12 level vector", irq_vector, 65);
    irq_in = '0;
    cycle();
    chk("R12 level withdrawn", irq_valid, 0);

    // Constrained random, checked cycle by cycle against the model
    for (int n = 0; n < 3000; n++) begin
      irq_in    = $urandom() & $urandom() & $urandom();
      cpu_mask  = 4'($urandom() % 8);
      irq_ready = 1'($urandom() % 2);
      if ($urandom() % 8 == 0) begin
        reg_wr_en = 1'b1;
        reg_addr  = 4'($urandom() % 10);
        reg_wdata = $urandom();
      end else begin
        reg_wr_en = 1'b0;
        reg_addr  = 4'($urandom() % 11);
      end
      cycle();
    end
    reg_wr_en = 1'b0;

    finish_run();
  end
endmodule